// File: doc/BRIEF.md
# Two-Port Handshaked Parallel Controller

This block holds two 8-bit parallel ports, A and B, each with a data register and a command register on a simple synchronous CPU bus. The peripheral side of each port has input pins, output pins with a per-bit output enable, an active-high ready output and an active-low strobe input. Each port runs in one of four modes: byte output, byte input, bidirectional (port A only) or bit control. A completed handshake, or a pattern match in bit-control mode, raises the port's interrupt request when interrupts are enabled for that port.

In bidirectional mode port A uses its own ready/strobe pair for output and takes over port B's pair for input. While port A is in that mode, port B runs in bit control. Strobes are synchronised to the system clock, so a strobe edge takes effect about three clocks after it reaches the pin.

Top module: `pp_ctrl`

Command word encoding. With bit 0 = 1 the word is a mode word: bits [2:1] select the mode (00 output, 01 input, 10 bidirectional, 11 bit control), bit 3 = 1 selects AND matching (0 selects OR), bit 4 = 1 matches high levels (0 matches low levels), and bit 5 is the interrupt enable. With bit 0 = 0 the word sets the interrupt enable from bit 7. A mode word that selects bit control makes the next two command writes load the direction mask (1 = input) and then the monitor mask (1 = monitored).

## Requirements
- R1: After reset both ports are in input mode. Both ready outputs and both interrupt requests are low, both output enables are 0x00, and a data read of port A returns 0x00.
- R2: In output mode a CPU data write places the byte on the port's output pins with the enable at all ones, and ready goes high on the next clock.
- R3: In input mode the output enable is 0x00. A CPU data read sets ready on the next clock. Pin data is latched while the synchronised strobe is low, and a later data read returns the latched byte.
- R4: When a strobe rises, ready falls within 6 clocks. If interrupts are enabled the port's interrupt request rises. Any CPU data read or write of that port clears the request.
- R5: With interrupts disabled, a completed handshake leaves the interrupt request low.
- R6: In bidirectional mode (port A, mode 10) a data write sets a_rdy. The port A pins are enabled with the output latch only while a_stb_n is low. b_stb_n low latches the pins into port A's input latch. A data read of port A sets b_rdy, and the rise of either strobe raises a_irq when interrupts are enabled.
- R7: While port A is bidirectional, port B behaves as bit control whatever mode was written to it, and b_rdy carries port A's input ready. A mode word asking port B for bidirectional mode is ignored.
- R8: In bit control the output enable is the inverse of the direction mask. A data read returns the pin value for input bits and the output latch for output bits.
- R9: In bit control the interrupt request rises when the condition on the monitored input bits becomes true: all of them for AND, any of them for OR, at the selected level. It does not rise again while the condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cpu_wr | input | 1 | CPU write strobe, one clock |
| cpu_rd | input | 1 | CPU read strobe, one clock |
| cpu_addr | input | 2 | Bit 1 selects port B, bit 0 selects the command register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Data register of the addressed port; 0 for command addresses |
| a_pin_in | input | 8 | Port A pin input |
| a_pin_out | output | 8 | Port A output latch |
| a_pin_oe | output | 8 | Port A per-bit output enable |
| a_rdy | output | 1 | Port A ready |
| a_stb_n | input | 1 | Port A strobe, active low |
| b_pin_in | input | 8 | Port B pin input |
| b_pin_out | output | 8 | Port B output latch |
| b_pin_oe | output | 8 | Port B per-bit output enable |
| b_rdy | output | 1 | Port B ready, or port A input ready in bidirectional mode |
| b_stb_n | input | 1 | Port B strobe, or port A input strobe in bidirectional mode |
| a_irq | output | 1 | Port A interrupt request |
| b_irq | output | 1 | Port B interrupt request |

## Verification
The hardest case to reach is the borrowed handshake. Port A has to be put in bidirectional mode with one output byte waiting and one input transfer armed. The stimulus then has to show that each strobe touches only its own half, and that port B's own mode word stays stored but has no effect. The bench writes an output byte and pulses a_stb_n while watching the enables. It then primes the input half with a read and pulses b_stb_n, and finally returns port A to output mode to show that port B's earlier mode word takes effect and that its bidirectional request was dropped.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    PM_OUT   = 2'd0,
    PM_IN    = 2'd1,
    PM_BIDIR = 2'd2,
    PM_BITS  = 2'd3
  } pp_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DIR  = 2'd1,
    SEQ_MSK  = 2'd2
  } pp_seq_e;

  // command word field positions
  localparam int unsigned CMD_IS_MODE = 0;
  localparam int unsigned CMD_MODE_LO = 1;
  localparam int unsigned CMD_ALL     = 3;
  localparam int unsigned CMD_HI      = 4;
  localparam int unsigned CMD_IE      = 5;
  localparam int unsigned CMD_IE_SET  = 7;
endpackage

// File: rtl/pp_stb_sync.sv
module pp_stb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_n,
  output logic low,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], stb_n};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign low  = ~sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~prev_q;

  // a rising edge is a single-cycle event
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pp_port.sv
module pp_port import pp_pkg::*; #(
  parameter int unsigned W        = 8,
  parameter bit          BIDIR_OK = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dat_wr,
  input  logic         dat_rd,
  input  logic         cmd_wr,
  input  logic [W-1:0] wdata,
  input  logic         force_bits,
  input  logic [W-1:0] pin_in,
  input  logic         stb_low,
  input  logic         stb_rise,
  input  logic         aux_low,
  input  logic         aux_rise,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         rdy,
  output logic         aux_rdy,
  output logic [W-1:0] rdata,
  output logic         irq,
  output pp_mode_e     mode_eff
);
  localparam logic [W-1:0] ONES = '1;

  // bit-control condition: all/any monitored input bits at the chosen level
  function automatic logic f_match(input logic [W-1:0] pins, input logic [W-1:0] dirm,
                                   input logic [W-1:0] selm, input logic all_of,
                                   input logic hi);
    logic [W-1:0] live;
    logic [W-1:0] hit;
    live = dirm & selm;
    hit  = hi ? pins : ~pins;
    if (live == '0) return 1'b0;
    return all_of ? ((hit & live) == live) : (|(hit & live));
  endfunction

  // read value in bit control: pins for inputs, latch for outputs
  function automatic logic [W-1:0] f_mix(input logic [W-1:0] pins, input logic [W-1:0] latch,
                                         input logic [W-1:0] dirm);
    return (pins & dirm) | (latch & ~dirm);
  endfunction

  pp_mode_e     mode_q;
  pp_seq_e      seq_q;
  logic         ie_q, all_q, hi_q;
  logic [W-1:0] dir_q, msk_q, out_q, in_q;
  logic         rdy_q, aux_q, pend_q, match_q;

  // named internal events
  pp_mode_e new_mode;
  logic     mode_wr, mode_ok, mode_take, ie_wr;
  logic     is_out, is_in, is_bidir, is_bits;
  logic     stb_done, aux_done, xfer_done, match_now, match_evt, irq_evt;

  assign new_mode  = pp_mode_e'(wdata[CMD_MODE_LO +: 2]);
  assign mode_wr   = cmd_wr && (seq_q == SEQ_IDLE) && wdata[CMD_IS_MODE];
  assign mode_ok   = BIDIR_OK || (new_mode != PM_BIDIR);
  assign mode_take = mode_wr && mode_ok;
  assign ie_wr     = cmd_wr && (seq_q == SEQ_IDLE) && !wdata[CMD_IS_MODE];

  assign mode_eff = force_bits ? PM_BITS : mode_q;
  assign is_out   = (mode_eff == PM_OUT);
  assign is_in    = (mode_eff == PM_IN);
  assign is_bidir = (mode_eff == PM_BIDIR);
  assign is_bits  = (mode_eff == PM_BITS);

  assign stb_done  = !is_bits && stb_rise;
  assign aux_done  = is_bidir && aux_rise;
  assign xfer_done = stb_done || aux_done;
  assign match_now = is_bits && f_match(pin_in, dir_q, msk_q, all_q, hi_q);
  assign match_evt = match_now && !match_q;
  assign irq_evt   = ie_q && (xfer_done || match_evt);

  // configuration and command sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_IN;
      seq_q  <= SEQ_IDLE;
      ie_q   <= 1'b0;
      all_q  <= 1'b0;
      hi_q   <= 1'b0;
      dir_q  <= '1;
      msk_q  <= '0;
    end else if (cmd_wr) begin
      case (seq_q)
        SEQ_DIR: begin
          dir_q <= wdata;
          seq_q <= SEQ_MSK;
        end
        SEQ_MSK: begin
          msk_q <= wdata;
          seq_q <= SEQ_IDLE;
        end
        default: begin
          if (wdata[CMD_IS_MODE]) begin
            if (mode_ok) begin
              mode_q <= new_mode;
              all_q  <= wdata[CMD_ALL];
              hi_q   <= wdata[CMD_HI];
              ie_q   <= wdata[CMD_IE];
              if (new_mode == PM_BITS) seq_q <= SEQ_DIR;
            end
          end else begin
            ie_q <= wdata[CMD_IE_SET];
          end
        end
      endcase
    end
  end

  // handshake, latches and interrupt state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      aux_q   <= 1'b0;
      pend_q  <= 1'b0;
      match_q <= 1'b0;
      out_q   <= '0;
      in_q    <= '0;
    end else begin
      if (mode_take)                       rdy_q <= 1'b0;
      else if ((is_out || is_bidir) && dat_wr) rdy_q <= 1'b1;
      else if (is_in && dat_rd)            rdy_q <= 1'b1;
      else if (stb_done || is_bits)        rdy_q <= 1'b0;

      if (mode_take)                   aux_q <= 1'b0;
      else if (is_bidir && dat_rd)     aux_q <= 1'b1;
      else if (aux_done || !is_bidir)  aux_q <= 1'b0;

      if (irq_evt) pend_q <= 1'b1;
      else if (dat_wr || dat_rd || (ie_wr && !wdata[CMD_IE_SET])) pend_q <= 1'b0;

      match_q <= match_now;

      if (dat_wr) out_q <= wdata;
      if ((is_in && stb_low) || (is_bidir && aux_low)) in_q <= pin_in;
    end
  end

  always_comb begin
    case (mode_eff)
      PM_OUT:   begin pin_oe = ONES;                   rdata = out_q; end
      PM_IN:    begin pin_oe = '0;                     rdata = in_q;  end
      PM_BIDIR: begin pin_oe = stb_low ? ONES : '0;    rdata = in_q;  end
      default:  begin pin_oe = ~dir_q;                 rdata = f_mix(pin_in, out_q, dir_q); end
    endcase
  end

  assign pin_out = out_q;
  assign rdy     = rdy_q;
  assign aux_rdy = BIDIR_OK ? aux_q : 1'b0;
  assign irq     = pend_q;

  p_out_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && is_out) |=> rdy_q);

  p_in_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && is_in) |=> rdy_q);

  p_rdy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_done && is_out && !dat_wr && !mode_take) |=> !rdy_q);

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(ie_q));

  p_match_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && ie_q) |=> pend_q);

  generate
    if (!BIDIR_OK) begin : g_no_bidir
      p_no_bidir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != PM_BIDIR);
    end
  endgenerate
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl import pp_pkg::*; #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [1:0]   cpu_addr,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic [W-1:0] a_pin_in,
  output logic [W-1:0] a_pin_out,
  output logic [W-1:0] a_pin_oe,
  output logic         a_rdy,
  input  logic         a_stb_n,
  input  logic [W-1:0] b_pin_in,
  output logic [W-1:0] b_pin_out,
  output logic [W-1:0] b_pin_oe,
  output logic         b_rdy,
  input  logic         b_stb_n,
  output logic         a_irq,
  output logic         b_irq
);
  localparam int unsigned NSTB = 2;

  logic [NSTB-1:0] stb_n_vec, stb_low, stb_rise;
  assign stb_n_vec = {b_stb_n, a_stb_n};

  generate
    for (genvar i = 0; i < NSTB; i++) begin : g_sync
      pp_stb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .stb_n(stb_n_vec[i]),
        .low  (stb_low[i]),
        .rise (stb_rise[i])
      );
    end
  endgenerate

  logic sel_b, sel_cmd;
  assign sel_b   = cpu_addr[1];
  assign sel_cmd = cpu_addr[0];

  logic a_dwr, a_drd, a_cwr, b_dwr, b_drd, b_cwr;
  assign a_dwr = cpu_wr && !sel_b && !sel_cmd;
  assign a_drd = cpu_rd && !sel_b && !sel_cmd;
  assign a_cwr = cpu_wr && !sel_b &&  sel_cmd;
  assign b_dwr = cpu_wr &&  sel_b && !sel_cmd;
  assign b_drd = cpu_rd &&  sel_b && !sel_cmd;
  assign b_cwr = cpu_wr &&  sel_b &&  sel_cmd;

  pp_mode_e     a_mode, b_mode;
  logic [W-1:0] a_rdata, b_rdata;
  logic         a_rdy_i, a_aux, b_rdy_i, b_aux, a_bidir;

  assign a_bidir = (a_mode == PM_BIDIR);

  pp_port #(.W(W), .BIDIR_OK(1'b1)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .dat_wr(a_dwr), .dat_rd(a_drd), .cmd_wr(a_cwr), .wdata(cpu_wdata),
    .force_bits(1'b0), .pin_in(a_pin_in),
    .stb_low(stb_low[0]), .stb_rise(stb_rise[0]),
    .aux_low(stb_low[1]), .aux_rise(stb_rise[1]),
    .pin_out(a_pin_out), .pin_oe(a_pin_oe), .rdy(a_rdy_i), .aux_rdy(a_aux),
    .rdata(a_rdata), .irq(a_irq), .mode_eff(a_mode)
  );

  pp_port #(.W(W), .BIDIR_OK(1'b0)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .dat_wr(b_dwr), .dat_rd(b_drd), .cmd_wr(b_cwr), .wdata(cpu_wdata),
    .force_bits(a_bidir), .pin_in(b_pin_in),
    .stb_low(stb_low[1]), .stb_rise(stb_rise[1]),
    .aux_low(1'b0), .aux_rise(1'b0),
    .pin_out(b_pin_out), .pin_oe(b_pin_oe), .rdy(b_rdy_i), .aux_rdy(b_aux),
    .rdata(b_rdata), .irq(b_irq), .mode_eff(b_mode)
  );

  assign a_rdy     = a_rdy_i;
  assign b_rdy     = a_bidir ? a_aux : (b_rdy_i | b_aux);
  assign cpu_rdata = sel_cmd ? '0 : (sel_b ? b_rdata : a_rdata);

  p_b_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_bidir |-> (b_mode == PM_BITS));

  p_b_rdy_borrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_bidir && !a_aux) |-> !b_rdy);
endmodule

// File: tb/test_pp_ctrl.sv
module test_pp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic [7:0] a_pin_in = 8'h00, b_pin_in = 8'h00;
  logic [7:0] a_pin_out, a_pin_oe, b_pin_out, b_pin_oe;
  logic       a_rdy, b_rdy, a_irq, b_irq;
  logic       a_stb_n = 1'b1, b_stb_n = 1'b1;

  always #5 clk = ~clk;

  pp_ctrl i_pp_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe), .a_rdy(a_rdy),
    .a_stb_n(a_stb_n), .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
    .b_rdy(b_rdy), .b_stb_n(b_stb_n), .a_irq(a_irq), .b_irq(b_irq)
  );

  // observable selectors
  localparam int O_RDATA = 0, O_A_OUT = 1, O_A_OE = 2, O_A_RDY = 3, O_B_RDY = 4,
                 O_A_IRQ = 5, O_B_IRQ = 6, O_B_OE = 7, O_B_OUT = 8;
  localparam logic [1:0] AD_A = 2'd0, AC_A = 2'd1, AD_B = 2'd2, AC_B = 2'd3;

  typedef struct {
    string      tag;
    int         sel;
    logic [7:0] exp;
  } chk_t;

  chk_t q[$];
  event smp_ev;
  int   checks = 0, failures = 0;
  bit   done = 1'b0;

  function automatic logic [7:0] obs(int sel);
    case (sel)
      O_RDATA: return cpu_rdata;
      O_A_OUT: return a_pin_out;
      O_A_OE:  return a_pin_oe;
      O_A_RDY: return {7'd0, a_rdy};
      O_B_RDY: return {7'd0, b_rdy};
      O_A_IRQ: return {7'd0, a_irq};
      O_B_IRQ: return {7'd0, b_irq};
      O_B_OE:  return b_pin_oe;
      default: return b_pin_out;
    endcase
  endfunction

  // monitor: compares queued expectations against the ports
  initial begin
    forever begin
      @(smp_ev);
      while (q.size() > 0) begin
        chk_t c;
        c = q.pop_front();
        checks++;
        if (obs(c.sel) !== c.exp) begin
          failures++;
          $display("FAIL %s: actual=%02h expected=%02h", c.tag, obs(c.sel), c.exp);
        end
      end
    end
  end

  task automatic expect_obs(string tag, int sel, logic [7:0] exp);
    q.push_back('{tag, sel, exp});
    -> smp_ev;
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a;
    #1;
    expect_obs(tag, O_RDATA, exp);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    @(negedge clk); a_stb_n = 1'b0; idle(4); a_stb_n = 1'b1; idle(6);
  endtask

  task automatic pulse_b();
    @(negedge clk); b_stb_n = 1'b0; idle(4); b_stb_n = 1'b1; idle(6);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    expect_obs("R1 a_rdy", O_A_RDY, 8'h00);
    expect_obs("R1 b_rdy", O_B_RDY, 8'h00);
    expect_obs("R1 a_irq", O_A_IRQ, 8'h00);
    expect_obs("R1 b_irq", O_B_IRQ, 8'h00);
    expect_obs("R1 a_oe", O_A_OE, 8'h00);
    expect_obs("R1 b_oe", O_B_OE, 8'h00);
    rd(AD_A, 8'h00, "R1 a data");

    // R2 output mode with interrupts enabled (0x21)
    wr(AC_A, 8'h21);
    wr(AD_A, 8'h5A);
    idle(1);
    expect_obs("R2 a_pin_out", O_A_OUT, 8'h5A);
    expect_obs("R2 a_oe", O_A_OE, 8'hFF);
    expect_obs("R2 a_rdy", O_A_RDY, 8'h01);
    // R4 strobe completes transfer
    pulse_a();
    expect_obs("R4 a_rdy drop", O_A_RDY, 8'h00);
    expect_obs("R4 a_irq", O_A_IRQ, 8'h01);
    wr(AD_A, 8'h3C);
    idle(1);
    expect_obs("R4 irq cleared by write", O_A_IRQ, 8'h00);
    expect_obs("R2 a_rdy again", O_A_RDY, 8'h01);
    expect_obs("R2 a_pin_out 2", O_A_OUT, 8'h3C);

    // R3 input mode, interrupts disabled (0x03)
    wr(AC_A, 8'h03);
    idle(1);
    expect_obs("R3 a_oe", O_A_OE, 8'h00);
    expect_obs("R3 a_rdy after mode", O_A_RDY, 8'h00);
    rd(AD_A, 8'h00, "R3 prime read");
    expect_obs("R3 a_rdy after read", O_A_RDY, 8'h01);
    a_pin_in = 8'hC3;
    pulse_a();
    expect_obs("R4 a_rdy drop in", O_A_RDY, 8'h00);
    expect_obs("R5 no irq when disabled", O_A_IRQ, 8'h00);
    a_pin_in = 8'h11;
    rd(AD_A, 8'hC3, "R3 latched data");

    // R6 bidirectional on A (0x25), R7 B locked
    wr(AC_B, 8'h01);              // B asks for output; stored but overridden
    wr(AC_A, 8'h25);
    idle(1);
    expect_obs("R7 b_oe locked", O_B_OE, 8'h00);
    wr(AD_A, 8'h96);
    idle(1);
    expect_obs("R6 a_rdy out waiting", O_A_RDY, 8'h01);
    expect_obs("R6 a_oe idle", O_A_OE, 8'h00);
    @(negedge clk); a_stb_n = 1'b0; idle(4);
    expect_obs("R6 a_oe while strobe", O_A_OE, 8'hFF);
    expect_obs("R6 a_pin_out", O_A_OUT, 8'h96);
    a_stb_n = 1'b1; idle(6);
    expect_obs("R6 a_oe released", O_A_OE, 8'h00);
    expect_obs("R6 a_rdy drop", O_A_RDY, 8'h00);
    expect_obs("R6 a_irq out", O_A_IRQ, 8'h01);
    rd(AD_A, 8'hC3, "R6 prime read");
    expect_obs("R7 b_rdy borrowed", O_B_RDY, 8'h01);
    expect_obs("R6 irq cleared", O_A_IRQ, 8'h00);
    a_pin_in = 8'h71;
    pulse_b();
    expect_obs("R7 b_rdy drop", O_B_RDY, 8'h00);
    expect_obs("R6 a_irq in", O_A_IRQ, 8'h01);
    expect_obs("R6 b_irq quiet", O_B_IRQ, 8'h00);
    rd(AD_A, 8'h71, "R6 input latched");

    // R7 release: B's stored output mode takes effect, bidir request ignored
    wr(AC_A, 8'h01);
    idle(1);
    expect_obs("R7 b_oe output", O_B_OE, 8'hFF);
    wr(AC_B, 8'h05);
    idle(1);
    expect_obs("R7 b bidir ignored", O_B_OE, 8'hFF);
    wr(AD_B, 8'hE1);
    idle(1);
    expect_obs("R7 b_pin_out", O_B_OUT, 8'hE1);

    // R8 bit control on B: AND, high, ie (0x3F), dir F0, mask 30
    b_pin_in = 8'h00;
    wr(AC_B, 8'h3F);
    wr(AC_B, 8'hF0);
    wr(AC_B, 8'h30);
    wr(AD_B, 8'h0A);
    idle(1);
    expect_obs("R8 b_oe", O_B_OE, 8'h0F);
    b_pin_in = 8'h55;
    rd(AD_B, 8'h5A, "R8 mixed read");
    idle(2);
    expect_obs("R9 partial AND no irq", O_B_IRQ, 8'h00);
    b_pin_in = 8'h75;
    idle(2);
    expect_obs("R9 AND match irq", O_B_IRQ, 8'h01);
    rd(AD_B, 8'h7A, "R8 read match");
    idle(3);
    expect_obs("R9 no repeat", O_B_IRQ, 8'h00);

    // R9 OR, low level (0x27), dir F0, mask C0
    wr(AC_B, 8'h27);
    wr(AC_B, 8'hF0);
    wr(AC_B, 8'hC0);
    b_pin_in = 8'hF0;
    idle(2);
    expect_obs("R9 OR low none", O_B_IRQ, 8'h00);
    b_pin_in = 8'hB0;
    idle(2);
    expect_obs("R9 OR low match", O_B_IRQ, 8'h01);

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule